// File: doc/BRIEF.md
# Conditional Branch Next-PC Unit

This block decides the program counter of the next instruction for a 32-bit in-order core. On each cycle with a valid instruction, it decodes the instruction word. It tests the supplied register value against zero and computes where execution goes next. The current PC is held in a register inside the block and advances on every valid instruction.

The block handles one conditional branch: the branch is taken when the tested register is non-zero. The branch comes in two forms. In the first, the target follows the branch at once, and the one instruction already fetched behind the branch is discarded. In the second, one slot instruction runs before the redirect. The block also tracks a one-instruction immediate prefix. The prefix supplies the upper half of a full-width offset, which replaces the default sign-extended 16-bit offset.

Alongside the next PC, the block reports four things for the current instruction: its cycle cost, a flush for the wrong-path fetch, whether an interrupt may be taken after it, and whether an illegal instruction sits in a slot.

Top module: `cbr_next_pc`

## Requirements
- R1: After reset, the PC is 0. No prefix is pending, so the first branch sign-extends its offset. No slot is open, so the first instruction follows the normal rules.
- R2: A branch is an instruction with bits [31:26] = 101111 and bits [24:21] = 0001. Bit 25 is the slot bit, and bits [15:0] hold the offset. An instruction with that opcode but any other value in bits [24:21] is handled as an ordinary instruction: next PC = PC+4, cost 1.
- R3: A branch with the slot bit clear and a non-zero tested register gives next PC = PC + sign-extended offset. It reports cost 3 and asserts flush for that instruction.
- R4: A branch with a zero tested register gives next PC = PC+4, cost 1, and no flush.
- R5: An instruction with bits [31:26] = 101100 is a prefix. Its bits [15:0] become the upper 16 bits of the offset used by the instruction that follows it, with no sign extension. The pending prefix is cleared by whatever instruction comes next, whether or not that instruction is a branch.
- R6: A taken branch with the slot bit set gives next PC = PC+4, cost 2, and no flush. The instruction that follows then goes to the branch target, with cost 1 and no flush.
- R7: A not-taken branch with the slot bit set still opens a slot. The slot instruction's next PC is the branch PC + 8.
- R8: irq_accept equals irq_req for a valid instruction, with two exceptions. It is held low when the instruction is a prefix, and when it is a branch with the slot bit set.
- R9: slot_err is raised when the instruction in a slot is a prefix, or has opcode 100110, 100111, 101110 or 101111. It is low otherwise.
- R10: The PC register loads the next PC only on cycles with instr_valid high. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word at the current PC |
| reg_val | input | 32 | Value of the register the branch tests |
| irq_req | input | 1 | Interrupt or break request |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Program counter after this instruction |
| flush | output | 1 | Discard the one wrong-path fetched instruction |
| cost | output | 2 | Cycles this instruction costs (1 to 3) |
| irq_accept | output | 1 | Request may be taken after this instruction |
| slot_err | output | 1 | Illegal instruction in a slot |

## Verification
On every cycle, the embedded assertions check these rules: the PC holds while idle; a slot-bit branch advances the PC by 4; a slot instruction never flushes or costs more than one cycle; a prefix always blocks interrupts; and the prefix flag clears after any non-prefix instruction. Only the bench's sequences can show the arithmetic results. These include backward and forward offsets, an offset made whole by a prefix, the target reached after a slot, the PC+8 result of a not-taken slot branch, and the prefix being forgotten across a reset.

// File: rtl/cbrnp_pkg.sv
package cbrnp_pkg;
    localparam int IMMW = 16;
    localparam logic [5:0] OP_BNE = 6'b101111;
    localparam logic [5:0] OP_PFX = 6'b101100;
    localparam logic [3:0] BNE_SUB = 4'b0001;

    typedef enum logic [1:0] {
        COST_ONE   = 2'd1,
        COST_TWO   = 2'd2,
        COST_THREE = 2'd3
    } cost_e;

    typedef struct packed {
        logic            is_bne;
        logic            dslot;
        logic            is_pfx;
        logic            is_ctrl;
        logic [IMMW-1:0] imm;
    } dec_t;

    function automatic logic is_ctrl_op(logic [5:0] op);
        return (op[5:4] == 2'b10) && (op[2:1] == 2'b11);
    endfunction
endpackage

// File: rtl/cbrnp_decode.sv
module cbrnp_decode
    import cbrnp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    localparam int OPLSB = XLEN - 6;

    logic [5:0] op;

    always_comb begin
        op          = instr[XLEN-1:OPLSB];
        dec.is_bne  = (op == OP_BNE) && (instr[OPLSB-2:OPLSB-5] == BNE_SUB);
        dec.dslot   = instr[OPLSB-1];
        dec.is_pfx  = (op == OP_PFX);
        dec.is_ctrl = is_ctrl_op(op);
        dec.imm     = instr[IMMW-1:0];
    end

    // R9: every branch is also a control-transfer instruction
    always_comb begin
        assert_bne_is_ctrl_R9: assert (!dec.is_bne || dec.is_ctrl);
    end
endmodule

// File: rtl/cbrnp_target.sv
module cbrnp_target
    import cbrnp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [IMMW-1:0] imm,
    input  logic            pfx_pend,
    input  logic [IMMW-1:0] pfx_hi,
    input  logic            taken,
    input  logic            dslot,
    input  logic            in_slot,
    input  logic [XLEN-1:0] slot_tgt,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] new_slot_tgt
);
    localparam int EXTW = XLEN - IMMW;

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] seq_pc;

    always_comb begin
        if (pfx_pend)
            imm_ext = XLEN'({pfx_hi, imm});
        else
            imm_ext = {{EXTW{imm[IMMW-1]}}, imm};
        br_tgt = pc + imm_ext;
        seq_pc = pc + XLEN'(4);
        if (in_slot)
            next_pc = slot_tgt;
        else if (taken && !dslot)
            next_pc = br_tgt;
        else
            next_pc = seq_pc;
        new_slot_tgt = taken ? br_tgt : (pc + XLEN'(8));
    end
endmodule

// File: rtl/cbr_next_pc.sv
module cbr_next_pc
    import cbrnp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] reg_val,
    input  logic            irq_req,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] next_pc,
    output logic            flush,
    output logic [1:0]      cost,
    output logic            irq_accept,
    output logic            slot_err
);
    dec_t            dec;
    logic [XLEN-1:0] pc_q;
    logic            pfx_q;
    logic [IMMW-1:0] pfx_hi_q;
    logic            slot_q;
    logic [XLEN-1:0] slot_tgt_q;
    logic [XLEN-1:0] new_slot_tgt;
    logic            taken;
    logic            opens_slot;
    cost_e           cost_w;

    cbrnp_decode #(.XLEN(XLEN)) u_decode (
        .instr (instr),
        .dec   (dec)
    );

    cbrnp_target #(.XLEN(XLEN)) u_target (
        .pc           (pc_q),
        .imm          (dec.imm),
        .pfx_pend     (pfx_q),
        .pfx_hi       (pfx_hi_q),
        .taken        (taken),
        .dslot        (dec.dslot),
        .in_slot      (slot_q),
        .slot_tgt     (slot_tgt_q),
        .next_pc      (next_pc),
        .new_slot_tgt (new_slot_tgt)
    );

    always_comb begin
        taken      = instr_valid && !slot_q && dec.is_bne && (reg_val != '0);
        opens_slot = instr_valid && !slot_q && dec.is_bne && dec.dslot;
        flush      = taken && !dec.dslot;
        if (taken)
            cost_w = dec.dslot ? COST_TWO : COST_THREE;
        else
            cost_w = COST_ONE;
        irq_accept = irq_req && instr_valid && !dec.is_pfx
                     && !(dec.is_bne && dec.dslot && !slot_q);
        slot_err   = instr_valid && slot_q && (dec.is_pfx || dec.is_ctrl);
    end

    assign cost = cost_w;
    assign pc   = pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= '0;
            pfx_q      <= 1'b0;
            pfx_hi_q   <= '0;
            slot_q     <= 1'b0;
            slot_tgt_q <= '0;
        end else if (instr_valid) begin
            pc_q   <= next_pc;
            pfx_q  <= dec.is_pfx;
            slot_q <= opens_slot;
            if (dec.is_pfx)
                pfx_hi_q <= dec.imm;
            if (opens_slot)
                slot_tgt_q <= new_slot_tgt;
        end
    end

    // R10: PC holds on idle cycles
    assert_pc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(pc_q));

    // R6: a slot-bit branch always moves to the slot instruction at PC+4
    assert_slot_step_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !slot_q && dec.is_bne && dec.dslot) |=> (pc_q == $past(pc_q) + XLEN'(4)));

    // R6: a slot instruction neither flushes nor stalls
    assert_slot_cheap_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && slot_q) |-> (!flush && cost == 2'd1));

    // R8: no interrupt accepted on a prefix
    assert_pfx_no_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && dec.is_pfx) |-> !irq_accept);

    // R5: prefix is consumed by the next instruction
    assert_pfx_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && pfx_q && !dec.is_pfx) |=> !pfx_q);

    // R3: flush only for a branch without slot
    assert_flush_cost_R3: assert property (@(posedge clk) disable iff (rst)
        flush |-> (cost == 2'd3 && instr_valid));

    // R9: slot error only inside a slot
    assert_err_in_slot_R9: assert property (@(posedge clk) disable iff (rst)
        slot_err |-> slot_q);
endmodule

// File: tb/cbr_next_pc_bench.sv
module cbr_next_pc_bench;
    typedef struct {
        logic [31:0] pc;
        logic [31:0] npc;
        logic        flush;
        logic [1:0]  cost;
        logic        irq_acc;
        logic        serr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] reg_val = '0;
    logic        irq_req = 1'b0;
    logic [31:0] pc, next_pc;
    logic        flush, irq_accept, slot_err;
    logic [1:0]  cost;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb[$];

    logic [31:0] m_pc;
    logic        m_pfx;
    logic [15:0] m_hi;
    logic        m_slot;
    logic [31:0] m_tgt;

    always #4 clk = ~clk;

    cbr_next_pc u_cbr_next_pc (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .reg_val(reg_val), .irq_req(irq_req), .pc(pc), .next_pc(next_pc),
        .flush(flush), .cost(cost), .irq_accept(irq_accept), .slot_err(slot_err)
    );

    function automatic logic [31:0] mk_bne(logic d, logic [15:0] imm);
        return {6'b101111, d, 4'b0001, 5'd3, imm};
    endfunction

    function automatic logic [31:0] mk_pfx(logic [15:0] hi);
        return {6'b101100, 10'd0, hi};
    endfunction

    localparam logic [31:0] ADD  = 32'h0000_0000;
    localparam logic [31:0] BRU  = {6'b100110, 26'd0};
    localparam logic [31:0] ODD  = {6'b101111, 1'b0, 4'b0010, 5'd3, 16'h0040};

    task automatic model_reset();
        m_pc = '0; m_pfx = 1'b0; m_hi = '0; m_slot = 1'b0; m_tgt = '0;
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] rv,
                         input logic irq, input string tag);
        exp_t e;
        logic [5:0]  op;
        logic        bne, d, pfx, ctrl, tk;
        logic [31:0] off, btgt;
        @(negedge clk);
        instr_valid = 1'b1; instr = ins; reg_val = rv; irq_req = irq;
        op   = ins[31:26];
        bne  = (op == 6'b101111) && (ins[24:21] == 4'b0001);
        d    = ins[25];
        pfx  = (op == 6'b101100);
        ctrl = (op == 6'b100110) || (op == 6'b100111) || (op == 6'b101110) || (op == 6'b101111);
        off  = m_pfx ? {m_hi, ins[15:0]} : {{16{ins[15]}}, ins[15:0]};
        btgt = m_pc + off;
        tk   = !m_slot && bne && (rv != 0);
        e.pc = m_pc; e.tag = tag;
        e.flush = tk && !d;
        e.cost = tk ? (d ? 2'd2 : 2'd3) : 2'd1;
        e.irq_acc = irq && !pfx && !(bne && d && !m_slot);
        e.serr = m_slot && (pfx || ctrl);
        if (m_slot) e.npc = m_tgt;
        else if (tk && !d) e.npc = btgt;
        else e.npc = m_pc + 4;
        sb.push_back(e);
        if (!m_slot && bne && d) begin
            m_tgt = tk ? btgt : m_pc + 8;
            m_slot = 1'b1;
        end else begin
            m_slot = 1'b0;
        end
        m_pfx = pfx;
        if (pfx) m_hi = ins[15:0];
        m_pc = e.npc;
    endtask

    task automatic idle();
        @(negedge clk);
        instr_valid = 1'b0; irq_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; instr_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (pc !== e.pc || next_pc !== e.npc || flush !== e.flush ||
                    cost !== e.cost || irq_accept !== e.irq_acc || slot_err !== e.serr) begin
                    n_bad++;
                    $display("FAIL %s: act pc=%h npc=%h fl=%b c=%0d irq=%b err=%b exp pc=%h npc=%h fl=%b c=%0d irq=%b err=%b",
                             e.tag, pc, next_pc, flush, cost, irq_accept, slot_err,
                             e.pc, e.npc, e.flush, e.cost, e.irq_acc, e.serr);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: act running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        n_vec++;
        if (pc !== 32'h0) begin
            n_bad++;
            $display("FAIL R1: act pc=%h exp pc=%h", pc, 32'h0);
        end
        apply(mk_bne(1'b0, 16'h0010), 32'd5, 1'b0, "R3 forward");
        apply(mk_bne(1'b0, 16'h0040), 32'd0, 1'b0, "R4 not taken");
        apply(mk_bne(1'b0, 16'hFFF0), 32'd1, 1'b0, "R3 backward");
        apply(mk_pfx(16'h1234), 32'd0, 1'b1, "R5 R8 prefix");
        apply(mk_bne(1'b0, 16'h0000), 32'd1, 1'b1, "R5 full offset");
        apply(mk_bne(1'b0, 16'h8000), 32'd1, 1'b0, "R5 prefix consumed");
        apply(mk_pfx(16'h0000), 32'd0, 1'b0, "R5 prefix again");
        apply(ADD, 32'd0, 1'b1, "R5 R8 plain after prefix");
        apply(mk_bne(1'b0, 16'hFFFC), 32'd7, 1'b0, "R5 sext after clear");
        apply(mk_bne(1'b1, 16'h0100), 32'd3, 1'b1, "R6 R8 slot branch");
        apply(ADD, 32'd0, 1'b1, "R6 slot to target");
        apply(mk_bne(1'b1, 16'h0100), 32'd0, 1'b0, "R7 slot not taken");
        apply(ADD, 32'd0, 1'b0, "R7 slot plus 8");
        apply(ODD, 32'd9, 1'b0, "R2 other sub-field");
        idle(); idle(); idle();
        apply(ADD, 32'd0, 1'b0, "R10 pc held");
        apply(mk_bne(1'b1, 16'h0020), 32'd1, 1'b0, "R6 open slot");
        apply(mk_pfx(16'h0001), 32'd0, 1'b0, "R9 prefix in slot");
        apply(ADD, 32'd0, 1'b0, "R9 after slot");
        apply(mk_bne(1'b1, 16'h0020), 32'd1, 1'b0, "R6 open slot 2");
        apply(mk_bne(1'b0, 16'h0400), 32'd1, 1'b0, "R9 branch in slot");
        apply(mk_bne(1'b1, 16'h0008), 32'd0, 1'b0, "R7 open slot 3");
        apply(BRU, 32'd0, 1'b0, "R9 jump in slot");
        apply(BRU, 32'd0, 1'b1, "R9 jump outside slot");
        apply(mk_pfx(16'h7777), 32'd0, 1'b0, "R1 prefix before reset");
        idle();
        do_reset();
        apply(mk_bne(1'b0, 16'hFFFC), 32'd1, 1'b0, "R1 prefix gone");
        apply(ADD, 32'd0, 1'b0, "R1 no slot after reset");
        idle(); idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule